// File: doc/BRIEF.md
# SPI Slave Shift Engine

This block is the serial core of an SPI slave port. While the active-low select is asserted, it takes one 8-bit character in on MOSI and sends one character out on MISO for each group of eight SCK clocks. It hands received characters to the register side through a small receive queue. SCK, MOSI and select are asynchronous to the system clock, so each one passes through a synchronizer before any logic uses it. MOSI is sampled on the rising SCK edge. MISO changes on the falling edge, and the most significant bit goes first.

The register side writes a pending transmit character. That character moves into the shift register only at a character boundary, and only if enough SCK rising edges have passed since the write. If the write comes too late, the slave sends back the character it just received, and the pending character waits for the next boundary. The first character of a transaction always comes from the shift register as it stood before select fell, never from a new write. Three flags tell software what to do: transmit-empty (write the next character), receive-ready (read a character), and transaction-done (select has been released).

Top module: `spi_slave_engine`

## Requirements
- R1: While ss_n is high the block is idle. miso_oe is low, SCK edges shift nothing, and no character is received.
- R2: While selected, MOSI is sampled on each rising SCK edge and MISO changes on each falling SCK edge, most significant bit first. MISO shows bit 7 of the outgoing character before the first rising edge.
- R3: On the rising edge that brings in bit 0 of a character, the character goes into a 2-entry receive queue. flag_rxc is high while the queue holds data. rx_rdata shows the oldest entry, and a one-cycle rx_re pulse removes it. A character that arrives while the queue is full is discarded.
- R4: flag_txc sets when ss_n returns high after being low. It clears on a txc_clr pulse, and nothing else clears it.
- R5: The first character of a transaction is the shift-register content left from before (0x00 after reset, otherwise the last character loaded or echoed). A write made before the transaction does not replace it.
- R6: A pending character is loaded at a character boundary only if at least three rising SCK edges, counting the last bit's edge, have passed since the write. Otherwise it is not loaded there.
- R7: When nothing is ready to load at a boundary, the next character sent is the character just received. A pending write that is not yet ready stays pending for a later boundary.
- R8: flag_dre goes low on the cycle after a tx_we pulse. It goes high exactly three system-clock cycles after the pending register empties, and also three cycles after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_wdata | input | 8 | Character to transmit |
| tx_we | input | 1 | One-cycle write strobe for tx_wdata |
| rx_rdata | output | 8 | Oldest received character |
| rx_re | input | 1 | One-cycle read strobe; removes the oldest character |
| flag_dre | output | 1 | Transmit pending register is empty |
| flag_rxc | output | 1 | Receive queue is not empty |
| flag_txc | output | 1 | Select has been released since the last clear |
| txc_clr | input | 1 | Clears flag_txc |
| sck | input | 1 | Serial clock from the master, idle low |
| mosi | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave select |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso |

## Verification
A bit counter that is out of step shows up within one character. The outgoing character starts loading in the middle of a byte, so the MISO byte the master collects is rotated, and the character pushed into the receive queue is misaligned. A wrong count of SCK edges since a write changes which character comes out after a boundary: the written data where an echo was expected, or the other way round. That is visible in the very next character. A pending-empty pipeline of the wrong length moves the rise of flag_dre by a cycle, and the bench checks that rise cycle by cycle.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  localparam int unsigned DEF_CHAR_W   = 8;
  localparam int unsigned DEF_SYNC     = 2;
  localparam int unsigned DEF_RX_DEPTH = 2;
  localparam int unsigned DEF_LOAD_LAG = 3;
  localparam int unsigned DEF_DRE_LAG  = 3;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= (chain << 1) | {{(STAGES-1){1'b0}}, din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_rx_queue.sv
module spi_rx_queue #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             not_empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign do_push = push && (count != CNT_W'(DEPTH));
  assign do_pop  = pop && (count != '0);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  assign rdata     = mem[rd_ptr];
  assign not_empty = (count != '0);

  // R3: a push without a pop always leaves data behind
  a_r3_push_visible: assert property (@(posedge clk) disable iff (rst)
    push && !pop |=> not_empty);
  // R3: a full queue drops the push and keeps its level
  a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
    push && !pop && count == CNT_W'(DEPTH) |=> count == CNT_W'(DEPTH));
endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine
  import spi_slave_pkg::*;
#(
  parameter int unsigned CHAR_W   = DEF_CHAR_W,
  parameter int unsigned SYNC     = DEF_SYNC,
  parameter int unsigned RX_DEPTH = DEF_RX_DEPTH,
  parameter int unsigned LOAD_LAG = DEF_LOAD_LAG,
  parameter int unsigned DRE_LAG  = DEF_DRE_LAG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAR_W-1:0] tx_wdata,
  input  logic              tx_we,
  output logic [CHAR_W-1:0] rx_rdata,
  input  logic              rx_re,
  output logic              flag_dre,
  output logic              flag_rxc,
  output logic              flag_txc,
  input  logic              txc_clr,
  input  logic              sck,
  input  logic              mosi,
  input  logic              ss_n,
  output logic              miso,
  output logic              miso_oe
);
  localparam int unsigned CNT_W = $clog2(CHAR_W);
  localparam int unsigned AGE_W = $clog2(LOAD_LAG + 1);

  logic sck_s, mosi_s, ss_s, sck_prev, ss_prev;

  spi_pin_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_sck  (.clk(clk), .rst(rst), .din(sck),  .dout(sck_s));
  spi_pin_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_mosi (.clk(clk), .rst(rst), .din(mosi), .dout(mosi_s));
  spi_pin_sync #(.STAGES(SYNC), .RST_VAL(1'b1)) u_ss   (.clk(clk), .rst(rst), .din(ss_n), .dout(ss_s));

  logic              sel, sck_rise, sck_fall, ss_rise, char_done, load_now, take, pv_n;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CHAR_W-1:0] rx_sh, tx_sh, rx_last, pend_data, rx_char;
  logic              pend_valid, at_boundary;
  logic [AGE_W-1:0]  age;
  logic [DRE_LAG-1:0] dre_pipe;

  assign sel       = ~ss_s;
  assign sck_rise  = sel & sck_s & ~sck_prev;
  assign sck_fall  = sel & ~sck_s & sck_prev;
  assign ss_rise   = ss_s & ~ss_prev;
  assign char_done = sck_rise && (bit_cnt == CNT_W'(CHAR_W - 1));
  assign rx_char   = {rx_sh[CHAR_W-2:0], mosi_s};
  assign load_now  = sck_fall && at_boundary;
  assign take      = load_now && pend_valid && (age == AGE_W'(LOAD_LAG));
  assign pv_n      = tx_we | (pend_valid & ~take);

  // Serial side: bit counting, receive and transmit shifting
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev    <= 1'b0;
      ss_prev     <= 1'b1;
      bit_cnt     <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      rx_last     <= '0;
      at_boundary <= 1'b0;
      miso_oe     <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      ss_prev  <= ss_s;
      miso_oe  <= sel;
      if (!sel) begin
        bit_cnt     <= '0;
        at_boundary <= 1'b0;
      end else if (sck_rise) begin
        bit_cnt <= char_done ? '0 : bit_cnt + 1'b1;
        rx_sh   <= rx_char;
        if (char_done) begin
          rx_last     <= rx_char;
          at_boundary <= 1'b1;
        end
      end else if (sck_fall) begin
        at_boundary <= 1'b0;
      end
      if (load_now)      tx_sh <= take ? pend_data : rx_last;
      else if (sck_fall) tx_sh <= tx_sh << 1;
    end
  end

  assign miso = tx_sh[CHAR_W-1];

  // Register side: pending character, edge age, flags
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_data  <= '0;
      pend_valid <= 1'b0;
      age        <= '0;
      dre_pipe   <= '0;
      flag_dre   <= 1'b0;
      flag_txc   <= 1'b0;
    end else begin
      pend_valid <= pv_n;
      if (tx_we) begin
        pend_data <= tx_wdata;
        age       <= '0;
      end else if (sck_rise && age != AGE_W'(LOAD_LAG)) begin
        age <= age + 1'b1;
      end
      dre_pipe <= (dre_pipe << 1) | {{(DRE_LAG-1){1'b0}}, ~pv_n};
      flag_dre <= dre_pipe[DRE_LAG-1] & ~pv_n;
      if (ss_rise)      flag_txc <= 1'b1;
      else if (txc_clr) flag_txc <= 1'b0;
    end
  end

  spi_rx_queue #(.WIDTH(CHAR_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(char_done), .wdata(rx_char),
    .pop(rx_re), .rdata(rx_rdata), .not_empty(flag_rxc));

  // R1: select held high keeps the output tri-stated
  a_r1_idle_tristate: assert property (@(posedge clk) disable iff (rst)
    ss_n && $past(ss_n) && $past(ss_n, 2) && $past(ss_n, 3) |-> !miso_oe);
  // R3: a completed character is visible on the register side next cycle
  a_r3_rx_ready: assert property (@(posedge clk) disable iff (rst)
    char_done |=> flag_rxc);
  // R4: the done flag only rises after select has gone high
  a_r4_txc_on_release: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_txc) |-> $past(ss_n));
  // R6: a new character enters the shifter only between characters
  a_r6_load_on_boundary: assert property (@(posedge clk) disable iff (rst)
    load_now |-> bit_cnt == '0);
  // R8: the empty flag rises only after the pending register has stayed empty
  a_r8_dre_lag: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_dre) |-> !$past(pend_valid) && !$past(pend_valid, 2));
endmodule

// File: tb/spi_slave_engine_test.sv
module spi_slave_engine_test;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_wdata = '0;
  logic       tx_we = 1'b0, rx_re = 1'b0, txc_clr = 1'b0;
  logic       sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;
  logic [7:0] rx_rdata;
  logic       flag_dre, flag_rxc, flag_txc, miso, miso_oe;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  // reference state computed from the requirements
  logic [7:0] ex_sh = 8'h00, ex_pend = 8'h00;
  bit         ex_pv = 1'b0;
  int         ex_age = 0;
  logic [7:0] exq [2];
  int         exn = 0;

  spi_slave_engine uut (
    .clk(clk), .rst(rst), .tx_wdata(tx_wdata), .tx_we(tx_we), .rx_rdata(rx_rdata),
    .rx_re(rx_re), .flag_dre(flag_dre), .flag_rxc(flag_rxc), .flag_txc(flag_txc),
    .txc_clr(txc_clr), .sck(sck), .mosi(mosi), .ss_n(ss_n), .miso(miso), .miso_oe(miso_oe));

  always #2 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] d);
    tx_wdata = d; tx_we = 1'b1; tick(1); tx_we = 1'b0;
    ex_pend = d; ex_pv = 1'b1; ex_age = 0;
  endtask

  // one character; wr_at = rise index after which a write is made (0 = none)
  task automatic xfer(input logic [7:0] mo, input int wr_at, input logic [7:0] wd,
                      input string tag, input bit dre_timing);
    logic [7:0] got;
    logic [7:0] exp_out;
    bit         loads;
    exp_out = ex_sh;
    for (int i = 0; i < 8; i++) begin
      mosi = mo[7-i];
      tick(HALF);
      got[7-i] = miso;
      sck = 1'b1;
      tick(HALF / 2);
      if (ex_age < 3) ex_age++;
      if (wr_at == i + 1) reg_write(wd);
      else tick(1);
      tick(HALF / 2 - 1);
      sck = 1'b0;
    end
    // boundary: receive and reload per R3, R6, R7
    if (exn < 2) begin exq[exn] = mo; exn++; end
    loads = ex_pv && ex_age >= 3;
    if (loads) begin ex_sh = ex_pend; ex_pv = 1'b0; end
    else ex_sh = mo;
    check(tag, {24'h0, got}, {24'h0, exp_out});
    if (dre_timing && loads) begin
      tick(5); check("R8 dre not yet", {31'h0, flag_dre}, 32'h0);
      tick(1); check("R8 dre after three", {31'h0, flag_dre}, 32'h1);
    end
  endtask

  task automatic select_on;
    ss_n = 1'b0; tick(HALF);
    check("R1 oe when selected", {31'h0, miso_oe}, 32'h1);
  endtask

  task automatic select_off;
    tick(HALF); ss_n = 1'b1; tick(HALF);
    check("R4 txc set", {31'h0, flag_txc}, 32'h1);
    check("R1 oe idle", {31'h0, miso_oe}, 32'h0);
    txc_clr = 1'b1; tick(1); txc_clr = 1'b0; tick(1);
    check("R4 txc cleared", {31'h0, flag_txc}, 32'h0);
    check("R8 dre level", {31'h0, flag_dre}, {31'h0, !ex_pv});
  endtask

  task automatic drain(input string tag);
    while (exn > 0) begin
      check({tag, " rxc"}, {31'h0, flag_rxc}, 32'h1);
      check({tag, " data"}, {24'h0, rx_rdata}, {24'h0, exq[0]});
      rx_re = 1'b1; tick(1); rx_re = 1'b0;
      exq[0] = exq[1]; exn--;
      tick(1);
    end
    check({tag, " empty"}, {31'h0, flag_rxc}, 32'h0);
  endtask

  initial begin
    tick(3);
    check("R8 reset dre", {31'h0, flag_dre}, 32'h0);
    check("R3 reset rxc", {31'h0, flag_rxc}, 32'h0);
    check("R4 reset txc", {31'h0, flag_txc}, 32'h0);
    check("R1 reset oe", {31'h0, miso_oe}, 32'h0);
    rst = 1'b0;
    tick(6);
    check("R8 dre after reset", {31'h0, flag_dre}, 32'h1);

    // R1: clocks while deselected do nothing
    for (int i = 0; i < 8; i++) begin
      mosi = i[0]; tick(HALF); sck = 1'b1;
      check("R1 idle oe", {31'h0, miso_oe}, 32'h0);
      tick(HALF); sck = 1'b0;
    end
    tick(HALF);
    check("R1 idle no receive", {31'h0, flag_rxc}, 32'h0);
    check("R4 idle no txc", {31'h0, flag_txc}, 32'h0);

    // R5 and R6: early write is held back for the first character, then loaded
    reg_write(8'hA5);
    tick(1);
    check("R8 dre cleared by write", {31'h0, flag_dre}, 32'h0);
    select_on();
    xfer(8'h3C, 0, 8'h00, "R5 first char is old shifter", 1'b1);
    xfer(8'h81, 0, 8'h00, "R6 preloaded char sent", 1'b0);
    select_off();
    drain("R3 two chars");

    // R7 late write echoes; R3 overflow drop of third char
    select_on();
    xfer(8'h12, 6, 8'h77, "R5 first char old", 1'b0);
    xfer(8'h34, 0, 8'h00, "R7 echo of received", 1'b0);
    xfer(8'h56, 0, 8'h00, "R7 late write kept", 1'b0);
    select_off();
    drain("R3 overflow");

    // R6: write with exactly three edges left is loaded
    select_on();
    xfer(8'h9A, 5, 8'h44, "R2 msb first", 1'b1);
    xfer(8'hBC, 0, 8'h00, "R6 three edges left", 1'b0);
    select_off();
    drain("R3 after R6");

    // random mix
    void'($urandom(32'h5EED));
    for (int t = 0; t < 30; t++) begin
      int n;
      n = 1 + ($urandom % 3);
      if ($urandom % 3 == 0) reg_write(8'($urandom));
      select_on();
      for (int c = 0; c < n; c++)
        xfer(8'($urandom), int'($urandom % 9), 8'($urandom), "R2 random char", 1'b0);
      select_off();
      drain("R3 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule